// File: doc/BRIEF.md
# Multi-Channel Transmit Frame Buffer with Programmed-I/O Loading

This block holds outgoing Ethernet frames that a processor writes one 32-bit word at a time, and then sends each frame as a byte stream toward a MAC core. There are several independent frame buffers, called channels. A channel-select register picks which buffer later payload writes go to. The processor writes the payload through a single data-port address, with the least significant byte of each word sent first. It then writes the frame's byte length into that channel's length register. Finally it sets bit 0 of that channel's control register.

Once bit 0 is set, the channel is busy. A single sequencer reads the buffer and puts out one byte per accepted transfer. The first byte of a frame is marked as start-of-frame and the last as end-of-frame. The busy flag clears by itself when the last byte has been accepted. At the same moment the channel's fill pointer returns to the start of its buffer, ready for the next frame.

If several channels are busy while the sequencer is idle, the lowest-numbered channel goes first. A channel can be loaded while another one is sending.

Top module: `tx_pio_fifo`

## Requirements
- R1: After reset, `tx_valid` is 0, every bit of `chan_busy` is 0, and the channel select is 0. So payload written without first writing the select lands in channel 0.
- R2: The write address map is fixed:
  - address 0 is channel select;
  - address 1 is the data port;
  - address 2+2c is the length register of channel c;
  - address 3+2c is the control register of channel c.
  A select write takes effect only when the value is below the channel count; other values leave the select unchanged.
- R3: Each data-port write stores one 32-bit word into the selected channel at its fill pointer. Bytes leave in write order, bits 7:0 of a word first and bits 31:24 last.
- R4: A frame emits exactly as many bytes as its length register holds. Any bytes of the final word beyond that length are never sent.
- R5: Writing a control register with bit 0 set, to an idle channel, sets that channel's busy bit at the next clock edge. If the sequencer is idle, the first byte is presented one cycle after busy rises, with `tx_sof` high. The final byte carries `tx_eof` high.
- R6: A channel's busy bit clears at the clock edge that accepts its end-of-frame byte. At that edge its fill pointer returns to word 0, and the sequencer shows no valid byte in the following cycle.
- R7: Data-port and length writes aimed at a busy channel are ignored.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_sof` and `tx_eof` hold their values.
- R9: When more than one channel is busy and the sequencer is idle, the lowest-numbered busy channel is sent first. Loading and starting other channels while a frame is being sent is allowed.
- R10: A start with length 0 clears busy one cycle after it rose, and no byte is sent. A length write above the buffer capacity (4 bytes times the word depth) stores the capacity.
- R11: Data-port writes made once a channel already holds its full word depth are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| chan_busy | output | NCH | Per-channel start/busy bit |
| tx_valid | output | 1 | Byte valid toward the MAC |
| tx_ready | input | 1 | MAC accepts the current byte |
| tx_data | output | 8 | Frame byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |

## Verification
The bound checker watches, on every cycle, the rules of the output stream:
- the byte and its markers stay still during a stall;
- start-of-frame appears exactly on the first byte after each end-of-frame;
- no frame runs past the buffer capacity;
- a busy bit rises only after a control write to that channel;
- a busy bit falls only at an accepted end-of-frame or outside a frame.

Only the bench's scenarios can show the rest:
- byte order within words;
- trimming of the final word;
- which channel wins;
- that writes to a busy or full channel changed nothing;
- that the fill pointer restarted.

The bench shows each of these by comparing the exact byte sequences of later frames.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned BYTE_W   = 8;

   // register map: select, data port, then a length/control pair per channel
   localparam int unsigned REG_SEL  = 0;
   localparam int unsigned REG_DATA = 1;

   function automatic int unsigned len_reg(input int unsigned ch);
      return 2 + 2 * ch;
   endfunction

   function automatic int unsigned ctl_reg(input int unsigned ch);
      return 3 + 2 * ch;
   endfunction

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SEND = 1'b1
   } tx_state_e;

endpackage

// File: rtl/tpf_regdec.sv
module tpf_regdec #(
   parameter int unsigned NCH    = 2,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CH_W   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   output logic [CH_W-1:0]   sel_q,
   output logic              data_we,
   output logic [NCH-1:0]    len_we,
   output logic [NCH-1:0]    ctl_we
);
   import tpf_pkg::*;

   logic sel_we;

   assign sel_we  = wr_en && (wr_addr == ADDR_W'(REG_SEL));
   assign data_we = wr_en && (wr_addr == ADDR_W'(REG_DATA));

   // out-of-range channel numbers leave the selection alone
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (sel_we && (wr_data < 32'(NCH))) begin
         sel_q <= wr_data[CH_W-1:0];
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_dec
      assign len_we[c] = wr_en && (wr_addr == ADDR_W'(len_reg(c)));
      assign ctl_we[c] = wr_en && (wr_addr == ADDR_W'(ctl_reg(c)));
   end

endmodule

// File: rtl/tpf_chan_buf.sv
module tpf_chan_buf #(
   parameter int unsigned DEPTH_WORDS = 16
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 sel_hit,
   input  logic                                 data_we,
   input  logic                                 len_we,
   input  logic                                 ctl_we,
   input  logic [31:0]                          wr_data,
   input  logic                                 done,
   input  logic [$clog2(DEPTH_WORDS)-1:0]       rd_idx,
   output logic                                 busy,
   output logic [$clog2(4*DEPTH_WORDS+1)-1:0]   len_q,
   output logic [31:0]                          rd_word
);
   localparam int unsigned CAP    = 4 * DEPTH_WORDS;
   localparam int unsigned LEN_W  = $clog2(CAP + 1);
   localparam int unsigned WIDX_W = $clog2(DEPTH_WORDS);
   localparam int unsigned PTR_W  = $clog2(DEPTH_WORDS + 1);

   logic [31:0]      mem [DEPTH_WORDS];
   logic [PTR_W-1:0] wptr_q;
   logic             busy_q;
   logic             fill_ok;
   logic             start_ok;
   logic [LEN_W-1:0] len_sat;

   assign fill_ok  = sel_hit && data_we && !busy_q && (wptr_q < PTR_W'(DEPTH_WORDS));
   assign start_ok = ctl_we && wr_data[0] && !busy_q;

   always_comb begin
      if (wr_data > 32'(CAP)) len_sat = LEN_W'(CAP);
      else                    len_sat = wr_data[LEN_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wptr_q <= '0;
         len_q  <= '0;
      end else begin
         if (done) begin
            busy_q <= 1'b0;
            wptr_q <= '0;
         end else begin
            if (start_ok) busy_q <= 1'b1;
            if (fill_ok)  wptr_q <= wptr_q + 1'b1;
         end
         if (len_we && !busy_q) len_q <= len_sat;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_ok) mem[wptr_q[WIDX_W-1:0]] <= wr_data;
   end

   assign rd_word = mem[rd_idx];
   assign busy    = busy_q;

endmodule

// File: rtl/tpf_sender.sv
module tpf_sender #(
   parameter int unsigned NCH         = 2,
   parameter int unsigned DEPTH_WORDS = 16,
   parameter int unsigned CH_W        = 1
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic [NCH-1:0]                           busy,
   input  logic [NCH*$clog2(4*DEPTH_WORDS+1)-1:0]   len_flat,
   input  logic [NCH*32-1:0]                        word_flat,
   input  logic                                     tx_ready,
   output logic [$clog2(DEPTH_WORDS)-1:0]           rd_idx,
   output logic [NCH-1:0]                           done,
   output logic                                     tx_valid,
   output logic [7:0]                               tx_data,
   output logic                                     tx_sof,
   output logic                                     tx_eof
);
   import tpf_pkg::*;

   localparam int unsigned CAP    = 4 * DEPTH_WORDS;
   localparam int unsigned LEN_W  = $clog2(CAP + 1);
   localparam int unsigned WIDX_W = $clog2(DEPTH_WORDS);

   tx_state_e        state_q;
   logic [CH_W-1:0]  cur_ch_q;
   logic [LEN_W-1:0] byte_q;

   logic             pick_found;
   logic [CH_W-1:0]  pick_ch;
   logic [LEN_W-1:0] pick_len;
   logic [LEN_W-1:0] cur_len;
   logic [31:0]      cur_word;
   logic             last_byte;
   logic             xfer;

   // lowest busy channel wins: scan downward so the last hit is the lowest
   always_comb begin
      pick_found = 1'b0;
      pick_ch    = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (busy[i]) begin
            pick_found = 1'b1;
            pick_ch    = CH_W'(i);
         end
      end
   end

   assign pick_len  = len_flat[pick_ch * LEN_W +: LEN_W];
   assign cur_len   = len_flat[cur_ch_q * LEN_W +: LEN_W];
   assign cur_word  = word_flat[cur_ch_q * 32 +: 32];
   assign rd_idx    = byte_q[WIDX_W+1:2];
   assign last_byte = (byte_q == cur_len - LEN_W'(1));

   assign tx_valid  = (state_q == ST_SEND);
   assign tx_data   = cur_word[{byte_q[1:0], 3'b000} +: 8];
   assign tx_sof    = tx_valid && (byte_q == '0);
   assign tx_eof    = tx_valid && last_byte;
   assign xfer      = tx_valid && tx_ready;

   always_comb begin
      done = '0;
      if ((state_q == ST_IDLE) && pick_found && (pick_len == '0)) done[pick_ch] = 1'b1;
      if (xfer && last_byte) done[cur_ch_q] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cur_ch_q <= '0;
         byte_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (pick_found && (pick_len != '0)) begin
                  cur_ch_q <= pick_ch;
                  byte_q   <= '0;
                  state_q  <= ST_SEND;
               end
            end
            ST_SEND: begin
               if (xfer) begin
                  if (last_byte) state_q <= ST_IDLE;
                  else           byte_q  <= byte_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tx_pio_fifo.sv
module tx_pio_fifo #(
   parameter int unsigned NCH         = 2,
   parameter int unsigned DEPTH_WORDS = 16,
   parameter int unsigned ADDR_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   output logic [NCH-1:0]    chan_busy,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_sof,
   output logic              tx_eof
);
   localparam int unsigned CAP    = 4 * DEPTH_WORDS;
   localparam int unsigned LEN_W  = $clog2(CAP + 1);
   localparam int unsigned WIDX_W = $clog2(DEPTH_WORDS);
   localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1;

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("tx_pio_fifo: NCH must be 1..8");
   end
   if (DEPTH_WORDS < 2) begin : g_bad_depth
      $error("tx_pio_fifo: DEPTH_WORDS must be at least 2");
   end
   if ((3 + 2 * NCH) > (1 << ADDR_W)) begin : g_bad_addr
      $error("tx_pio_fifo: ADDR_W too small for the register map");
   end

   logic [CH_W-1:0]        sel_q;
   logic                   data_we;
   logic [NCH-1:0]         len_we;
   logic [NCH-1:0]         ctl_we;
   logic [NCH-1:0]         done;
   logic [WIDX_W-1:0]      rd_idx;
   logic [NCH*LEN_W-1:0]   len_flat;
   logic [NCH*32-1:0]      word_flat;

   tpf_regdec #(.NCH(NCH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_regdec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .sel_q   (sel_q),
      .data_we (data_we),
      .len_we  (len_we),
      .ctl_we  (ctl_we)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      tpf_chan_buf #(.DEPTH_WORDS(DEPTH_WORDS)) u_buf (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel_hit (sel_q == CH_W'(c)),
         .data_we (data_we),
         .len_we  (len_we[c]),
         .ctl_we  (ctl_we[c]),
         .wr_data (wr_data),
         .done    (done[c]),
         .rd_idx  (rd_idx),
         .busy    (chan_busy[c]),
         .len_q   (len_flat[c*LEN_W +: LEN_W]),
         .rd_word (word_flat[c*32 +: 32])
      );
   end

   tpf_sender #(.NCH(NCH), .DEPTH_WORDS(DEPTH_WORDS), .CH_W(CH_W)) u_sender (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (chan_busy),
      .len_flat  (len_flat),
      .word_flat (word_flat),
      .tx_ready  (tx_ready),
      .rd_idx    (rd_idx),
      .done      (done),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .tx_sof    (tx_sof),
      .tx_eof    (tx_eof)
   );

endmodule

// File: rtl/tx_pio_fifo_chk.sv
module tx_pio_fifo_chk #(
   parameter int unsigned NCH         = 2,
   parameter int unsigned DEPTH_WORDS = 16,
   parameter int unsigned ADDR_W      = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [31:0]       wr_data,
   input logic [NCH-1:0]    chan_busy,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [7:0]        tx_data,
   input logic              tx_sof,
   input logic              tx_eof
);
   localparam int unsigned CAP   = 4 * DEPTH_WORDS;
   localparam int unsigned CNT_W = $clog2(CAP + 1) + 1;

   logic             in_frame_q;
   logic [CNT_W-1:0] nbytes_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         nbytes_q   <= '0;
      end else if (tx_valid && tx_ready) begin
         in_frame_q <= !tx_eof;
         nbytes_q   <= tx_eof ? '0 : nbytes_q + 1'b1;
      end
   end

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof));

   assert_sof_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !in_frame_q |-> tx_sof);

   assert_sof_only_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && in_frame_q |-> !tx_sof);

   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (nbytes_q < CNT_W'(CAP)));

   assert_valid_has_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (chan_busy != '0));

   for (genvar i = 0; i < NCH; i++) begin : g_chan_chk
      assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(chan_busy[i]) |-> $past(wr_en && wr_data[0] &&
                                       (wr_addr == ADDR_W'(tpf_pkg::ctl_reg(i)))));

      assert_busy_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(chan_busy[i]) |-> $past(!tx_valid || (tx_ready && tx_eof)));
   end

endmodule

bind tx_pio_fifo tx_pio_fifo_chk #(
   .NCH(NCH), .DEPTH_WORDS(DEPTH_WORDS), .ADDR_W(ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .chan_busy (chan_busy),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_data   (tx_data),
   .tx_sof    (tx_sof),
   .tx_eof    (tx_eof)
);

// File: tb/tx_pio_fifo_bench.sv
`timescale 1ns/1ps
module tx_pio_fifo_bench;
   localparam int NCH    = 3;
   localparam int DEPTH  = 16;
   localparam int ADDR_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [31:0]       wr_data = '0;
   logic [NCH-1:0]    chan_busy;
   logic              tx_valid;
   logic              tx_ready = 1'b0;
   logic [7:0]        tx_data;
   logic              tx_sof;
   logic              tx_eof;

   int n_run = 0;
   int n_fail = 0;
   int cyc_ctr = 0;

   always #2 clk = ~clk;

   tx_pio_fifo #(.NCH(NCH), .DEPTH_WORDS(DEPTH), .ADDR_W(ADDR_W)) u_tx_pio_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .chan_busy(chan_busy), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof)
   );

   always @(posedge clk) begin
      cyc_ctr++;
      if (cyc_ctr > 150000) begin
         n_run++; n_fail++;
         $display("FAIL watchdog R6 actual=hung expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((seed * 37 + i * 11 + 5));
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = 32'(data);
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic put_words(input int nb, input int seed);
      for (int w = 0; w < (nb + 3) / 4; w++) begin
         logic [31:0] word;
         word = '0;
         for (int b = 0; b < 4; b++) begin
            int idx;
            idx = 4 * w + b;
            word[8*b +: 8] = (idx < nb) ? pat(seed, idx) : 8'hEE;
         end
         wr(1, int'(word));
      end
   endtask

   task automatic load(input int ch, input int nb, input int len, input int seed, input bit do_sel);
      if (do_sel) wr(0, ch);
      put_words(nb, seed);
      wr(2 + 2 * ch, len);
   endtask

   task automatic start(input int ch);
      wr(3 + 2 * ch, 1);
   endtask

   task automatic collect(input int ch, input int nb, input int seed, input int mode, input string req);
      int k;
      int cyc;
      bit fin;
      bit stalled;
      logic [7:0] held;
      k = 0; cyc = 0; fin = 0; stalled = 0; held = '0;
      while (!fin && cyc < 4000) begin
         @(negedge clk);
         tx_ready = (mode == 0) ? 1'b1 : (cyc % 3 != 1);
         cyc++;
         #1;
         if (stalled) begin
            chk(tx_valid && tx_data == held, "R8", "stalled byte changed", int'(tx_data), int'(held));
            stalled = 0;
         end
         if (tx_valid && tx_ready) begin
            chk(tx_data == pat(seed, k), req, "byte value R3", int'(tx_data), int'(pat(seed, k)));
            chk(tx_sof == (k == 0), "R5", "sof marker", int'(tx_sof), int'(k == 0));
            chk(tx_eof == (k == nb - 1), "R4", "eof marker", int'(tx_eof), int'(k == nb - 1));
            if (tx_eof) fin = 1;
            k++;
         end else if (tx_valid) begin
            held = tx_data;
            stalled = 1;
         end
      end
      chk(fin && k == nb, req, "frame byte count", k, nb);
      @(negedge clk);
      tx_ready = 1'b0;
      #1;
      chk(chan_busy[ch] == 1'b0, "R6", "busy after eof", int'(chan_busy[ch]), 0);
      chk(tx_valid == 1'b0, "R6", "idle cycle after eof", int'(tx_valid), 0);
   endtask

   task automatic t_reset;
      @(negedge clk); #1;
      chk(tx_valid == 1'b0, "R1", "tx_valid at reset", int'(tx_valid), 0);
      chk(chan_busy == '0, "R1", "busy at reset", int'(chan_busy), 0);
   endtask

   // R1 R2 R3 R4 R5: default channel, 10 bytes in three words
   task automatic t_basic;
      tx_ready = 1'b0;
      put_words(10, 3);
      wr(2, 10);
      start(0);
      @(negedge clk); #1;
      chk(chan_busy == 3'b001, "R5", "busy after start", int'(chan_busy), 1);
      chk(tx_valid == 1'b0, "R5", "valid same cycle as busy", int'(tx_valid), 0);
      @(negedge clk); #1;
      chk(tx_valid && tx_sof, "R5", "first byte one cycle later", int'(tx_valid), 1);
      chk(tx_data == pat(3, 0), "R1", "default channel 0 byte", int'(tx_data), int'(pat(3, 0)));
      collect(0, 10, 3, 0, "R3");
   endtask

   task automatic t_partial_stall;
      load(1, 7, 7, 9, 1);
      start(1);
      collect(1, 7, 9, 1, "R4");
      load(0, 13, 13, 21, 1);
      start(0);
      collect(0, 13, 21, 1, "R8");
   endtask

   task automatic t_busy_ignore;
      tx_ready = 1'b0;
      load(0, 8, 8, 33, 1);
      start(0);
      wr(1, 32'h1234_5678);
      wr(1, 32'h0BAD_F00D);
      wr(2, 3);
      collect(0, 8, 33, 0, "R7");
      load(0, 6, 6, 44, 0);
      start(0);
      collect(0, 6, 44, 0, "R6");
   endtask

   task automatic t_priority;
      tx_ready = 1'b0;
      load(1, 12, 12, 51, 1);
      start(1);
      load(2, 6, 6, 52, 1);
      start(2);
      wr(0, 0);
      wr(0, 6);
      put_words(9, 53);
      wr(2, 9);
      start(0);
      @(negedge clk); #1;
      chk(chan_busy == 3'b111, "R9", "all channels busy", int'(chan_busy), 7);
      collect(1, 12, 51, 0, "R9");
      collect(0, 9, 53, 0, "R9");
      collect(2, 6, 52, 0, "R2");
   endtask

   task automatic t_zero_sat;
      load(0, 8, 0, 61, 1);
      start(0);
      @(negedge clk); #1;
      chk(chan_busy[0] == 1'b1, "R10", "zero length busy rises", int'(chan_busy[0]), 1);
      @(negedge clk); #1;
      chk(chan_busy[0] == 1'b0, "R10", "zero length busy clears", int'(chan_busy[0]), 0);
      chk(tx_valid == 1'b0, "R10", "zero length sends nothing", int'(tx_valid), 0);
      load(0, 68, 100, 62, 0);
      start(0);
      collect(0, 64, 62, 0, "R11");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_partial_stall();
      t_busy_ignore();
      t_priority();
      t_zero_sat();
      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule